// File: doc/BRIEF.md
# Indexed register access controller

This block is the host-facing register front end of a small data-acquisition peripheral. The host sees four byte-wide locations on a 2-bit address bus. Location 0 holds an index. Location 1 is a window onto whichever internal register the index names. Locations 2 and 3 carry the 12-bit converter word directly, outside the index scheme. That word is split into a low nibble and a high byte.

The block decodes each host read and write. It keeps the channel-select, user LED and index registers, and holds the two DAC output words. It forwards strobes to the converter, to the counter/timer and to the digital I/O sub-blocks. Two small state machines (`idxr_event`) track the pending events. Each has the states EV_IDLE and EV_HELD. EV_IDLE goes to EV_HELD on a set event. EV_HELD goes back to EV_IDLE on a clear event, unless a set event arrives in the same cycle. One machine tracks unread ADC results. The other tracks rising edges on timer channel 1. The status byte is built from these two machines, and the single interrupt request is their OR.

Top module: `idx_reg_front`

## Requirements
- R1: After reset the index is 00h, the channel select is 0, the LED is off, both DAC words are 000h, `irq` is low and a window read at index 00h returns 03h.
- R2: A write to location 0 loads the full byte into the index. A read of location 0 returns 00h.
- R3: A window write at index 00h raises `adc_start` in that same cycle. A window write at index 01h stores data bits 3:0 in `mux_sel`, and a window read there returns them with the upper bits zero.
- R4: A one-cycle `adc_done` pulse clears status bit 0 and raises `irq` from the next cycle. A read of location 3 returns `adc_data[11:4]` and sets status bit 0 back to 1. If `adc_done` arrives in the same cycle as that read, the bit stays at 0.
- R5: A read of location 2 returns `adc_data[3:0]` in bits 3:0 and zero in bits 7:4.
- R6: A rising edge on `tmr1_out` clears status bit 1 and raises `irq`. Any window write at index 08h sets the bit back to 1, unless a new rising edge comes in the same cycle.
- R7: At index 02h, a write to location 2 stages data bits 7:4 and leaves the DAC A output unchanged. A following write to location 3 sets `dac_a_val` to {data, staged nibble} and pulses `dac_a_load` for exactly the next cycle. Index 03h does the same for DAC B.
- R8: Writes to locations 2 or 3 at any index other than 02h or 03h change neither DAC word.
- R9: At index 80h, bit 0 of a window write drives `user_led`, and a window read returns {0000000, LED}. A window read at index 81h always returns 2Dh, and writes there have no effect.
- R10: At indexes 04h to 07h and 09h to 0Bh, window accesses raise `periph_wr` or `periph_rd` in the same cycle, with `periph_idx` equal to the index bits 3:0. A window read there returns `periph_rdata`.
- R11: Window reads at index 08h, at 0Ch to 7Fh and at 82h to FFh return 00h. Window writes at 0Ch to 7Fh and at 82h to FFh change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Host location select |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational |
| adc_start | output | 1 | Starts a software-triggered conversion |
| adc_done | input | 1 | Conversion complete pulse |
| adc_data | input | 12 | Converter result |
| mux_sel | output | 4 | Analog input channel select |
| dac_a_val | output | 12 | DAC A output word |
| dac_a_load | output | 1 | DAC A update pulse |
| dac_b_val | output | 12 | DAC B output word |
| dac_b_load | output | 1 | DAC B update pulse |
| tmr1_out | input | 1 | Timer channel 1 output |
| periph_wr | output | 1 | Forwarded write strobe |
| periph_rd | output | 1 | Forwarded read strobe |
| periph_idx | output | 4 | Forwarded register select |
| periph_wdata | output | 8 | Forwarded write data |
| periph_rdata | input | 8 | Forwarded read data |
| user_led | output | 1 | User LED drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, a 12-bit converter word (so a 4-bit low nibble), a 4-bit channel select and an identification byte of 2Dh. These values bring within reach the exact nibble and byte split of both DAC words, the zero fill of the low-nibble read, and every boundary of the index windows. Among those boundaries are 03h/04h, 07h/08h, 0Bh/0Ch, 7Fh/80h and 81h/82h. They also bring within reach the two same-cycle races, where a set event and a clear event land on one edge in each tracker.

// File: rtl/idxr_pkg.sv
package idxr_pkg;
    localparam int IDX_W = 8;

    localparam logic [1:0] OFS_INDEX = 2'd0;
    localparam logic [1:0] OFS_WIN   = 2'd1;
    localparam logic [1:0] OFS_DLO   = 2'd2;
    localparam logic [1:0] OFS_DHI   = 2'd3;

    localparam logic [IDX_W-1:0] IX_STATUS = 8'h00;
    localparam logic [IDX_W-1:0] IX_MUX    = 8'h01;
    localparam logic [IDX_W-1:0] IX_DACA   = 8'h02;
    localparam logic [IDX_W-1:0] IX_TCLR   = 8'h08;
    localparam logic [IDX_W-1:0] IX_LED    = 8'h80;
    localparam logic [IDX_W-1:0] IX_ID     = 8'h81;

    typedef enum logic {EV_IDLE, EV_HELD} ev_state_t;

    // indexes handed to the timer and digital I/O sub-blocks
    function automatic logic in_fwd(input logic [IDX_W-1:0] ix);
        return ((ix >= 8'h04) && (ix <= 8'h07)) || ((ix >= 8'h09) && (ix <= 8'h0B));
    endfunction
endpackage

// File: rtl/idxr_event.sv
module idxr_event
    import idxr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pend
);
    ev_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EV_IDLE;
        else        st_q <= st_d;
    end

    // a new event in the same cycle as a clear keeps the state held
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EV_IDLE: if (set_evt) st_d = EV_HELD;
            EV_HELD: if (clr_evt && !set_evt) st_d = EV_IDLE;
        endcase
    end

    always_comb begin
        pend = (st_q == EV_HELD);
    end
endmodule

// File: rtl/idxr_dac_chan.sv
module idxr_dac_chan #(
    parameter int HI_W = 8,
    parameter int LO_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [LO_W-1:0]      lo_in,
    input  logic [HI_W-1:0]      hi_in,
    output logic [HI_W+LO_W-1:0] val,
    output logic                 load
);
    logic [LO_W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            val     <= '0;
            load    <= 1'b0;
        end else begin
            load <= wr_hi;
            if (wr_lo) stage_q <= lo_in;
            if (wr_hi) val <= {hi_in, stage_q};
        end
    end
endmodule

// File: rtl/idxr_decode.sv
module idxr_decode
    import idxr_pkg::*;
(
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [IDX_W-1:0] idx,
    output logic             idx_we,
    output logic             mux_we,
    output logic             led_we,
    output logic             adc_go,
    output logic             tmr_clr,
    output logic             fwd_wr,
    output logic             fwd_rd,
    output logic             dlo_wr,
    output logic             dhi_wr,
    output logic             dhi_rd
);
    logic win_wr, win_rd;

    always_comb begin
        win_wr  = wr && (addr == OFS_WIN);
        win_rd  = rd && (addr == OFS_WIN);
        idx_we  = wr && (addr == OFS_INDEX);
        mux_we  = win_wr && (idx == IX_MUX);
        led_we  = win_wr && (idx == IX_LED);
        adc_go  = win_wr && (idx == IX_STATUS);
        tmr_clr = win_wr && (idx == IX_TCLR);
        fwd_wr  = win_wr && in_fwd(idx);
        fwd_rd  = win_rd && in_fwd(idx);
        dlo_wr  = wr && (addr == OFS_DLO);
        dhi_wr  = wr && (addr == OFS_DHI);
        dhi_rd  = rd && (addr == OFS_DHI);
    end
endmodule

// File: rtl/idx_reg_front.sv
module idx_reg_front
    import idxr_pkg::*;
#(
    parameter int              DW      = 8,
    parameter int              CW      = 12,
    parameter int              MUX_W   = 4,
    parameter int              PIDX_W  = 4,
    parameter logic [DW-1:0]   ID_BYTE = 8'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              adc_start,
    input  logic              adc_done,
    input  logic [CW-1:0]     adc_data,
    output logic [MUX_W-1:0]  mux_sel,
    output logic [CW-1:0]     dac_a_val,
    output logic              dac_a_load,
    output logic [CW-1:0]     dac_b_val,
    output logic              dac_b_load,
    input  logic              tmr1_out,
    output logic              periph_wr,
    output logic              periph_rd,
    output logic [PIDX_W-1:0] periph_idx,
    output logic [DW-1:0]     periph_wdata,
    input  logic [DW-1:0]     periph_rdata,
    output logic              user_led,
    output logic              irq
);
    localparam int LO_W   = CW - DW;
    localparam int N_DAC  = 2;

    logic [IDX_W-1:0] idx_q;
    logic [MUX_W-1:0] mux_q;
    logic             led_q;
    logic             tmr_prev_q;
    logic             tmr_rise;
    logic             adc_full, tmr_pend;

    logic idx_we, mux_we, led_we, tmr_clr, dlo_wr, dhi_wr, dhi_rd;

    logic [CW-1:0] dac_val  [N_DAC];
    logic          dac_load [N_DAC];

    idxr_decode u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .idx     (idx_q),
        .idx_we  (idx_we),
        .mux_we  (mux_we),
        .led_we  (led_we),
        .adc_go  (adc_start),
        .tmr_clr (tmr_clr),
        .fwd_wr  (periph_wr),
        .fwd_rd  (periph_rd),
        .dlo_wr  (dlo_wr),
        .dhi_wr  (dhi_wr),
        .dhi_rd  (dhi_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            mux_q      <= '0;
            led_q      <= 1'b0;
            tmr_prev_q <= 1'b0;
        end else begin
            tmr_prev_q <= tmr1_out;
            if (idx_we) idx_q <= bus_wdata;
            if (mux_we) mux_q <= bus_wdata[MUX_W-1:0];
            if (led_we) led_q <= bus_wdata[0];
        end
    end

    assign tmr_rise = tmr1_out && !tmr_prev_q;

    idxr_event u_adc_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (adc_done),
        .clr_evt (dhi_rd),
        .pend    (adc_full)
    );

    idxr_event u_tmr_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (tmr_rise),
        .clr_evt (tmr_clr),
        .pend    (tmr_pend)
    );

    for (genvar g = 0; g < N_DAC; g++) begin : g_dac
        localparam logic [IDX_W-1:0] SEL = IX_DACA + IDX_W'(g);
        idxr_dac_chan #(.HI_W(DW), .LO_W(LO_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (dlo_wr && (idx_q == SEL)),
            .wr_hi (dhi_wr && (idx_q == SEL)),
            .lo_in (bus_wdata[DW-1 -: LO_W]),
            .hi_in (bus_wdata),
            .val   (dac_val[g]),
            .load  (dac_load[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_INDEX: bus_rdata = '0;
            OFS_WIN: begin
                if (idx_q == IX_STATUS)   bus_rdata = {{(DW-2){1'b0}}, !tmr_pend, !adc_full};
                else if (idx_q == IX_MUX) bus_rdata = {{(DW-MUX_W){1'b0}}, mux_q};
                else if (idx_q == IX_LED) bus_rdata = {{(DW-1){1'b0}}, led_q};
                else if (idx_q == IX_ID)  bus_rdata = ID_BYTE;
                else if (in_fwd(idx_q))   bus_rdata = periph_rdata;
                else                      bus_rdata = '0;
            end
            OFS_DLO: bus_rdata = {{(DW-LO_W){1'b0}}, adc_data[LO_W-1:0]};
            OFS_DHI: bus_rdata = adc_data[CW-1:LO_W];
        endcase
    end

    assign periph_idx   = idx_q[PIDX_W-1:0];
    assign periph_wdata = bus_wdata;
    assign mux_sel      = mux_q;
    assign user_led     = led_q;
    assign dac_a_val    = dac_val[0];
    assign dac_a_load   = dac_load[0];
    assign dac_b_val    = dac_val[1];
    assign dac_b_load   = dac_load[1];
    assign irq          = adc_full || tmr_pend;
endmodule

// File: rtl/idx_reg_front_chk.sv
module idx_reg_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_addr,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [7:0]  idx_q,
    input logic        adc_start,
    input logic        adc_done,
    input logic        tmr1_out,
    input logic        irq,
    input logic [11:0] dac_a_val,
    input logic        dac_a_load,
    input logic [11:0] dac_b_val,
    input logic        dac_b_load
);
    // R4
    adc_done_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_done |=> irq);

    // R6
    tmr_rise_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr1_out) |=> irq);

    // R3
    start_only_on_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (bus_wr && bus_addr == 2'd1 && idx_q == 8'h00));

    // R7
    dac_a_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && idx_q == 8'h02) |=>
            (dac_a_load && dac_a_val[11:4] == $past(bus_wdata)));

    // R7
    dac_b_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && idx_q == 8'h03) |=>
            (dac_b_load && dac_b_val[11:4] == $past(bus_wdata)));

    // R8
    dac_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_a_load |-> $stable(dac_a_val));

    // R8
    dac_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_b_load |-> $stable(dac_b_val));

    // R9
    id_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1 && idx_q == 8'h81) |-> (bus_rdata == 8'h2D));

    // R2
    index_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata == 8'h00));
endmodule

bind idx_reg_front idx_reg_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .idx_q      (idx_q),
    .adc_start  (adc_start),
    .adc_done   (adc_done),
    .tmr1_out   (tmr1_out),
    .irq        (irq),
    .dac_a_val  (dac_a_val),
    .dac_a_load (dac_a_load),
    .dac_b_val  (dac_b_val),
    .dac_b_load (dac_b_load)
);

// File: tb/tb_idx_reg_front.sv
module tb_idx_reg_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        adc_start, adc_done = 1'b0;
    logic [11:0] adc_data = 12'hABC;
    logic [3:0]  mux_sel;
    logic [11:0] dac_a_val, dac_b_val;
    logic        dac_a_load, dac_b_load;
    logic        tmr1_out = 1'b0;
    logic        periph_wr, periph_rd;
    logic [3:0]  periph_idx;
    logic [7:0]  periph_wdata, periph_rdata;
    logic        user_led, irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    assign periph_rdata = {4'hA, periph_idx};

    idx_reg_front dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_start(adc_start),
        .adc_done(adc_done), .adc_data(adc_data), .mux_sel(mux_sel),
        .dac_a_val(dac_a_val), .dac_a_load(dac_a_load), .dac_b_val(dac_b_val),
        .dac_b_load(dac_b_load), .tmr1_out(tmr1_out), .periph_wr(periph_wr),
        .periph_rd(periph_rd), .periph_idx(periph_idx), .periph_wdata(periph_wdata),
        .periph_rdata(periph_rdata), .user_led(user_led), .irq(irq)
    );

    // vector: {write, addr, data, expected read, requirement number}
    localparam int NV = 23;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 2'd0, 8'h01, 8'h00, 4'd3},
        {1'b1, 2'd1, 8'hF7, 8'h00, 4'd3},
        {1'b0, 2'd1, 8'h00, 8'h07, 4'd3},   // R3 channel select readback
        {1'b1, 2'd0, 8'h80, 8'h00, 4'd9},
        {1'b1, 2'd1, 8'h01, 8'h00, 4'd9},
        {1'b0, 2'd1, 8'h00, 8'h01, 4'd9},   // R9 LED readback
        {1'b1, 2'd0, 8'h81, 8'h00, 4'd9},
        {1'b1, 2'd1, 8'hFF, 8'h00, 4'd9},
        {1'b0, 2'd1, 8'h00, 8'h2D, 4'd9},   // R9 identification byte
        {1'b1, 2'd0, 8'h05, 8'h00, 4'd10},
        {1'b0, 2'd1, 8'h00, 8'hA5, 4'd10},  // R10 forwarded read
        {1'b1, 2'd0, 8'h7F, 8'h00, 4'd11},
        {1'b1, 2'd1, 8'h55, 8'h00, 4'd11},
        {1'b0, 2'd1, 8'h00, 8'h00, 4'd11},  // R11 unused reads zero
        {1'b1, 2'd0, 8'h80, 8'h00, 4'd11},
        {1'b0, 2'd1, 8'h00, 8'h01, 4'd11},  // R11 unused write left LED alone
        {1'b1, 2'd0, 8'h08, 8'h00, 4'd11},
        {1'b0, 2'd1, 8'h00, 8'h00, 4'd11},  // R11 index 08h reads zero
        {1'b0, 2'd0, 8'h00, 8'h00, 4'd2},   // R2 index location reads zero
        {1'b1, 2'd0, 8'h82, 8'h00, 4'd11},
        {1'b0, 2'd1, 8'h00, 8'h00, 4'd11},
        {1'b1, 2'd0, 8'h00, 8'h00, 4'd1},
        {1'b0, 2'd1, 8'h00, 8'h03, 4'd1}    // R1 status idle
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        total++; bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 led", user_led, 0);
        chk("R1 dac_a", dac_a_val, 0);
        chk("R1 dac_b", dac_b_val, 0);
        chk("R1 mux", mux_sel, 0);
        rd(2'd1, 8'h03, "R1 status");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][22]) wr(VEC[i][21:20], VEC[i][19:12]);
            else rd(VEC[i][21:20], VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
        end
        chk("R3 mux port", mux_sel, 4'h7);
        chk("R9 led port", user_led, 1);

        // R10 forwarded write strobe
        wr(2'd0, 8'h0B);
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'h3C; bus_wr = 1'b1;
        #1 chk("R10 periph_wr", {periph_wr, periph_idx, periph_wdata}, {1'b1, 4'hB, 8'h3C});
        @(negedge clk); bus_wr = 1'b0;
        wr(2'd0, 8'h0C);
        @(negedge clk);
        bus_addr = 2'd1; bus_rd = 1'b1;
        #1 chk("R10 no strobe at 0Ch", periph_rd, 0);
        @(negedge clk); bus_rd = 1'b0;

        // R3 start strobe
        wr(2'd0, 8'h00);
        @(negedge clk);
        bus_addr = 2'd1; bus_wr = 1'b1;
        #1 chk("R3 adc_start", adc_start, 1);
        @(negedge clk); bus_wr = 1'b0;
        #1 chk("R3 adc_start low", adc_start, 0);

        // R4 conversion complete
        @(negedge clk); adc_done = 1'b1;
        @(negedge clk); adc_done = 1'b0;
        chk("R4 irq", irq, 1);
        rd(2'd1, 8'h02, "R4 status busy");
        rd(2'd2, 8'h0C, "R5 low nibble");
        rd(2'd3, 8'hAB, "R4 high byte");
        chk("R4 irq cleared", irq, 0);
        rd(2'd1, 8'h03, "R4 status clear");
        // R4 done and high-byte read in the same cycle
        @(negedge clk); adc_done = 1'b1;
        @(negedge clk); adc_done = 1'b1; bus_addr = 2'd3; bus_rd = 1'b1;
        @(negedge clk); adc_done = 1'b0; bus_rd = 1'b0;
        rd(2'd1, 8'h02, "R4 race keeps ready");
        rd(2'd3, 8'hAB, "R4 drain");

        // R6 timer edge
        @(negedge clk); tmr1_out = 1'b1;
        @(negedge clk);
        chk("R6 irq", irq, 1);
        rd(2'd1, 8'h01, "R6 status pending");
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h00);
        chk("R6 irq cleared", irq, 0);
        @(negedge clk); tmr1_out = 1'b0;
        @(negedge clk);
        bus_addr = 2'd1; bus_wr = 1'b1; tmr1_out = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        chk("R6 race keeps pending", irq, 1);
        wr(2'd1, 8'h00);
        tmr1_out = 1'b0;
        chk("R6 final clear", irq, 0);

        // R7 DAC A then DAC B
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h5F);
        chk("R7 stage only", dac_a_val, 12'h000);
        wr(2'd3, 8'hAB);
        chk("R7 dac_a", {dac_a_load, dac_a_val}, {1'b1, 12'hAB5});
        @(negedge clk);
        chk("R7 load one cycle", dac_a_load, 0);
        wr(2'd0, 8'h03);
        wr(2'd2, 8'hC0);
        wr(2'd3, 8'h12);
        chk("R7 dac_b", {dac_b_load, dac_b_val}, {1'b1, 12'h12C});
        chk("R7 dac_a kept", dac_a_val, 12'hAB5);

        // R8 other index
        wr(2'd0, 8'h04);
        wr(2'd2, 8'h70);
        wr(2'd3, 8'hFF);
        chk("R8 dac_a", dac_a_val, 12'hAB5);
        chk("R8 dac_b", dac_b_val, 12'h12C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule